// File: doc/BRIEF.md
# Configuration Port Unlock and Register Banking Controller

This block puts a configuration register space behind two byte-wide I/O addresses: an index port and a data port. At reset the space is hidden. A host opens it by writing a fixed four-byte key to the index port. Once open, each index write picks a configuration register, and data-port writes and reads reach that register. The host closes the space with a command written through the same index/data pair.

The register space has three parts. There is a logical-device select register, and read-only identification bytes that give a 16-bit chip ID and a 4-bit revision. There is also one per-device register bank that exists only while its logical device is selected. The bank contents go out on a flat bus to the block that owns that device. Reads of the data port have no side effects and are returned combinationally.

Top module: `cfg_port_ctrl`

## Requirements
- R1: After reset the port is closed (`cfg_open` = 0), the logical-device select is 0x00 and every bank byte is 0x00.
- R2: The port opens on the clock edge that takes the last of four index-port writes carrying 0x87, 0x01, 0x55, 0x55 in that order. Writes to any other address do not advance or disturb the key detector.
- R3: While the port is closed, an index-port byte that does not match the expected key byte sends the detector back to its start. If that byte equals 0x87, the detector counts it as the first key byte.
- R4: While the port is closed, data-port writes change no register, and reads of either port return 0xFF.
- R5: While the port is open, key bytes have no special effect. Every index-port write loads the index register, and reading the index port returns it.
- R6: Writing 0x02 to configuration index 0x02 closes the port. Any other value written to index 0x02 leaves it open. Index 0x02 reads 0xFF.
- R7: Index 0x07 is the logical-device select register. It is readable, writable and driven on `ldn_sel`, and it keeps its value while the port is closed.
- R8: Index 0x20 reads the high byte of the chip ID, index 0x21 reads the low byte, and index 0x22 reads the revision in bits 3:0 with bits 7:4 zero.
- R9: With logical device 0x07 selected, indices 0x70 to 0x77 read and write eight bank bytes. Bank byte i appears on `bank_q[8*i+7:8*i]`.
- R10: With any other logical device selected, bank writes are ignored and bank indices read 0xFF. Every index not named above reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O address of the current access |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_rdata | output | 8 | Read data for `io_addr`, combinational |
| cfg_open | output | 1 | Configuration space is unlocked |
| ldn_sel | output | 8 | Selected logical device number |
| bank_q | output | 8*BANK_REGS | Contents of the logical-device bank |

## Verification
The hardest case to reach from the ports is a key sequence that breaks at a particular step with a particular byte. This matters most when the breaking byte is itself the first key byte, because the detector must then restart from step two rather than step one. The bench covers this by sweeping every step position against all 256 byte values. After each broken prefix it writes the rest of the key, and it expects the port to open only when the swept byte was the correct one. Writes that are ignored while the port is closed can only be seen after reopening it, so the bench unlocks afterwards and reads the device select and the bank back.

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl #(
  parameter int              ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_ADDR = 16'h002E,
  parameter logic [ADDR_W-1:0] DATA_ADDR  = 16'h002F,
  parameter logic [15:0]     CHIP_ID    = 16'h8728,
  parameter logic [3:0]      CHIP_REV   = 4'h2,
  parameter logic [7:0]      BANK_LDN   = 8'h07,
  parameter int              BANK_BASE  = 'h70,
  parameter int              BANK_REGS  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      io_addr,
  input  logic [7:0]             io_wdata,
  input  logic                   io_wr,
  output logic [7:0]             io_rdata,
  output logic                   cfg_open,
  output logic [7:0]             ldn_sel,
  output logic [8*BANK_REGS-1:0] bank_q
);
  localparam logic [7:0] IDX_EXIT  = 8'h02;
  localparam logic [7:0] CMD_EXIT  = 8'h02;
  localparam logic [7:0] IDX_LDN   = 8'h07;
  localparam logic [7:0] IDX_ID_HI = 8'h20;
  localparam logic [7:0] IDX_ID_LO = 8'h21;
  localparam logic [7:0] IDX_REV   = 8'h22;

  logic [1:0] step_q;
  logic [7:0] index_q;
  logic [7:0] ldn_q;
  logic [8*BANK_REGS-1:0] bank_r;
  logic [7:0] key_exp;
  logic [7:0] reg_rd;

  wire idx_wr  = io_wr && (io_addr == INDEX_ADDR);
  wire data_wr = io_wr && (io_addr == DATA_ADDR) && cfg_open;
  wire ldn_hit = (ldn_q == BANK_LDN);

  always_comb begin
    case (step_q)
      2'd0:    key_exp = 8'h87;
      2'd1:    key_exp = 8'h01;
      default: key_exp = 8'h55;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q   <= 2'd0;
      cfg_open <= 1'b0;
      index_q  <= 8'h00;
      ldn_q    <= 8'h00;
      bank_r   <= '0;
    end else begin
      if (!cfg_open && idx_wr) begin
        if (io_wdata == key_exp) begin
          step_q <= step_q + 2'd1;
          if (step_q == 2'd3) cfg_open <= 1'b1;
        end else begin
          step_q <= (io_wdata == 8'h87) ? 2'd1 : 2'd0;
        end
      end
      if (cfg_open && idx_wr) index_q <= io_wdata;
      if (data_wr) begin
        if (index_q == IDX_EXIT && io_wdata == CMD_EXIT) cfg_open <= 1'b0;
        if (index_q == IDX_LDN) ldn_q <= io_wdata;
        for (int i = 0; i < BANK_REGS; i++)
          if (ldn_hit && index_q == 8'(BANK_BASE + i))
            bank_r[8*i +: 8] <= io_wdata;
      end
    end
  end

  always_comb begin
    reg_rd = 8'hFF;
    case (index_q)
      IDX_LDN:   reg_rd = ldn_q;
      IDX_ID_HI: reg_rd = CHIP_ID[15:8];
      IDX_ID_LO: reg_rd = CHIP_ID[7:0];
      IDX_REV:   reg_rd = {4'h0, CHIP_REV};
      default: begin
        for (int i = 0; i < BANK_REGS; i++)
          if (ldn_hit && index_q == 8'(BANK_BASE + i))
            reg_rd = bank_r[8*i +: 8];
      end
    endcase
  end

  always_comb begin
    io_rdata = 8'hFF;
    if (cfg_open) begin
      if (io_addr == INDEX_ADDR)     io_rdata = index_q;
      else if (io_addr == DATA_ADDR) io_rdata = reg_rd;
    end
  end

  assign ldn_sel = ldn_q;
  assign bank_q  = bank_r;
endmodule

// File: rtl/cfg_port_ctrl_chk.sv
module cfg_port_ctrl_chk #(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_ADDR = 16'h002E,
  parameter logic [ADDR_W-1:0] DATA_ADDR  = 16'h002F,
  parameter logic [7:0]        BANK_LDN   = 8'h07,
  parameter int                BANK_REGS  = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ADDR_W-1:0]      io_addr,
  input logic [7:0]             io_wdata,
  input logic                   io_wr,
  input logic                   cfg_open,
  input logic [7:0]             idx,
  input logic [7:0]             ldn,
  input logic [8*BANK_REGS-1:0] bank
);
  AST_OPEN_AFTER_KEY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(io_wr && io_addr == INDEX_ADDR && io_wdata == 8'h55)); // R2

  AST_LOCKED_LDN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> $stable(ldn)); // R4

  AST_OPEN_INDEX_KEEPS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_open && io_wr && io_addr == INDEX_ADDR |=> cfg_open); // R5

  AST_EXIT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_open && io_wr && io_addr == DATA_ADDR && idx == 8'h02 && io_wdata == 8'h02 |=> !cfg_open); // R6

  AST_BANK_HELD_OTHER_LDN: assert property (@(posedge clk) disable iff (!rst_n)
    ldn != BANK_LDN |=> $stable(bank)); // R10
endmodule

bind cfg_port_ctrl cfg_port_ctrl_chk #(
  .ADDR_W(ADDR_W), .INDEX_ADDR(INDEX_ADDR), .DATA_ADDR(DATA_ADDR),
  .BANK_LDN(BANK_LDN), .BANK_REGS(BANK_REGS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
  .io_wr(io_wr), .cfg_open(cfg_open), .idx(index_q), .ldn(ldn_q), .bank(bank_r)
);

// File: tb/cfg_port_ctrl_tb.sv
module cfg_port_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] IA = 16'h002E;
  localparam logic [15:0] DA = 16'h002F;
  localparam logic [7:0] KEY [4] = '{8'h87, 8'h01, 8'h55, 8'h55};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0] io_wdata = '0;
  logic io_wr = 1'b0;
  logic [7:0] io_rdata;
  logic cfg_open;
  logic [7:0] ldn_sel;
  logic [63:0] bank_q;

  int checks = 0;
  int fails = 0;
  logic [7:0] shadow [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_port_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rdata(io_rdata), .cfg_open(cfg_open),
    .ldn_sel(ldn_sel), .bank_q(bank_q)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v);
    io_addr = a;
    #1;
    v = io_rdata;
  endtask

  task automatic cfg_wr(input logic [7:0] idx, input logic [7:0] d);
    wr(IA, idx);
    wr(DA, d);
  endtask

  task automatic cfg_rd(input logic [7:0] idx, output logic [7:0] v);
    wr(IA, idx);
    rd(DA, v);
  endtask

  task automatic unlock();
    for (int j = 0; j < 4; j++) wr(IA, KEY[j]);
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] idx, input logic [7:0] ldn);
    if (idx == 8'h07) return ldn;
    if (idx == 8'h20) return 8'h87;
    if (idx == 8'h21) return 8'h28;
    if (idx == 8'h22) return 8'h02;
    if (ldn == 8'h07 && idx >= 8'h70 && idx <= 8'h77) return shadow[idx - 8'h70];
    return 8'hFF;
  endfunction

  function automatic logic [63:0] shadow_flat();
    logic [63:0] f;
    for (int i = 0; i < 8; i++) f[8*i +: 8] = shadow[i];
    return f;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 8; i++) shadow[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R1 open after reset", cfg_open, 1'b0);
    check("R1 ldn after reset", ldn_sel, 8'h00);
    check("R1 bank after reset", bank_q, 64'h0);
    rd(DA, v); check("R4 locked data read", v, 8'hFF);
    rd(IA, v); check("R4 locked index read", v, 8'hFF);

    // R4: locked data writes, then key bytes to data port must not count (R2)
    wr(DA, 8'h07); wr(DA, 8'h5A);
    for (int j = 0; j < 4; j++) wr(DA, KEY[j]);
    check("R2 key on data port ignored", cfg_open, 1'b0);
    for (int j = 0; j < 3; j++) begin
      wr(IA, KEY[j]);
      check("R2 not open before last key byte", cfg_open, 1'b0);
    end
    wr(IA, KEY[3]);
    check("R2 open after key", cfg_open, 1'b1);
    cfg_rd(8'h07, v); check("R4 locked writes ignored ldn", v, 8'h00);

    // R3: sweep every break step against every byte value
    cfg_wr(8'h02, 8'h02);
    for (int k = 0; k < 4; k++) begin
      for (int b = 0; b < 256; b++) begin
        wr(IA, 8'h00);
        for (int j = 0; j < k; j++) wr(IA, KEY[j]);
        wr(IA, 8'(b));
        for (int j = k + 1; j < 4; j++) wr(IA, KEY[j]);
        check("R3 broken key sweep", cfg_open, (8'(b) == KEY[k]));
        if (cfg_open) cfg_wr(8'h02, 8'h02);
      end
    end
    wr(IA, 8'h87); wr(IA, 8'h87); wr(IA, 8'h01); wr(IA, 8'h55); wr(IA, 8'h55);
    check("R3 repeated first byte restarts", cfg_open, 1'b1);

    // R5: key bytes while open load index
    unlock();
    check("R5 still open", cfg_open, 1'b1);
    rd(IA, v); check("R5 index readback", v, 8'h55);
    wr(IA, 8'h3C); rd(IA, v); check("R5 index load", v, 8'h3C);

    // R6
    cfg_wr(8'h02, 8'h03); check("R6 wrong exit value", cfg_open, 1'b1);
    rd(DA, v); check("R6 exit index reads FF", v, 8'hFF);

    // R7/R8
    cfg_wr(8'h07, 8'h07); check("R7 ldn port", ldn_sel, 8'h07);
    for (int i = 0; i < 8; i++) begin
      shadow[i] = 8'((i * 37 + 5) & 8'hFF);
      cfg_wr(8'(8'h70 + i), shadow[i]);
    end
    check("R9 bank export", bank_q, shadow_flat());
    for (int x = 0; x < 256; x++) begin
      cfg_rd(8'(x), v);
      check("R8 R9 R10 read sweep ldn7", v, exp_rd(8'(x), 8'h07));
    end
    cfg_wr(8'h07, 8'h03);
    for (int i = 0; i < 8; i++) cfg_wr(8'(8'h70 + i), 8'hEE);
    check("R10 bank unchanged other ldn", bank_q, shadow_flat());
    for (int x = 0; x < 256; x++) begin
      cfg_rd(8'(x), v);
      check("R8 R10 read sweep ldn3", v, exp_rd(8'(x), 8'h03));
    end

    // R6 close, R4 locked writes, R7 ldn retained
    cfg_wr(8'h07, 8'h07);
    cfg_wr(8'h02, 8'h02); check("R6 exit closes", cfg_open, 1'b0);
    wr(DA, 8'h99); wr(IA, 8'h07); wr(DA, 8'h11);
    check("R4 locked bank unchanged", bank_q, shadow_flat());
    check("R7 ldn held while closed", ldn_sel, 8'h07);
    unlock();
    cfg_rd(8'h02, v); check("R6 reg2 still FF", v, 8'hFF);
    cfg_rd(8'h07, v); check("R7 ldn readback", v, 8'h07);
    cfg_rd(8'h75, v); check("R9 bank readback", v, shadow[5]);

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset clears open", cfg_open, 1'b0);
    check("R1 reset clears bank", bank_q, 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule